// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick-enable strobe into periodic interrupt events. A free-running 15-bit tick counter advances on each qualified tick. A 4-bit rate code selects a power-of-two period, and an event fires on every tick that brings the counter to a multiple of that period. Events therefore line up with the running count. They are not timed from the moment the rate was programmed.

Each event produces a one-cycle flag-set pulse and a matching interrupt-request set pulse for the status logic that follows. The rate code is nonlinear. Code 0 turns events off. Codes 1 and 2 act as codes 8 and 9. Any other code n gives a period of 2^(n-1) ticks. A divider-running qualifier gates the tick, and a synchronous clear restarts the count.

Top module: `periodic_rate_gen`

## Requirements
- R1: After the asynchronous reset, both outputs are low and the tick count is zero, so with a fixed nonzero rate the first event comes on the tick that brings the count to one full period.
- R2: With rate code 0, no flag pulse and no request pulse is produced, whatever the ticks do.
- R3: For rate codes 3 to 15, an event fires every 2^(code-1) ticks; for example, code 3 gives 4 ticks, code 6 gives 32 ticks and code 15 gives 16384 ticks.
- R4: Rate code 1 behaves as code 8 (128 ticks) and rate code 2 behaves as code 9 (256 ticks).
- R5: An event fires on the tick whose incremented count has its low (effective code - 1) bits all zero. A rate change applies from the next tick and emits no event of its own.
- R6: While the periodic enable is low, no pulse is produced, but the tick count keeps advancing.
- R7: The request pulse appears in exactly the cycles in which the flag pulse appears, and never on its own.
- R8: A tick received while the divider-running qualifier is low is ignored: the count holds and no event fires.
- R9: The synchronous clear sets the count to zero. It takes priority over a tick in the same cycle, and that cycle produces no event.
- R10: Each pulse is high for exactly one clock cycle.
- R11: An event's pulses are high in the clock cycle that follows the edge on which the tick was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the tick count |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle per tick |
| run_i | input | 1 | Divider-running qualifier |
| rate_i | input | 4 | Rate code |
| pie_i | input | 1 | Periodic interrupt enable |
| pf_set_o | output | 1 | Periodic flag set pulse |
| irq_set_o | output | 1 | Interrupt request set pulse |

## Verification
The assertions check the gating rules on every cycle:
- the request never appears without the flag;
- no pulse follows a cycle with code 0, with the enable low, with the qualifier low or with a clear active;
- every pulse lasts a single cycle.

Only the bench scenarios can show that events land on the correct tick. These scenarios cover each period, the aliasing of codes 1 and 2, and alignment to the running count across mid-stream rate changes. They also show that the count held while the qualifier was low and that it restarted after a clear.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned PRG_CNT_W  = 15;
  localparam int unsigned PRG_RATE_W = 4;
  // low codes remapped to slower rates
  localparam int unsigned PRG_ALIAS_1 = 8;
  localparam int unsigned PRG_ALIAS_2 = 9;
endpackage

// File: rtl/prg_tick_cnt.sv
module prg_tick_cnt #(
  parameter int unsigned CNT_W = prg_pkg::PRG_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/prg_rate_dec.sv
module prg_rate_dec #(
  parameter int unsigned RATE_W = prg_pkg::PRG_RATE_W,
  parameter int unsigned CNT_W  = prg_pkg::PRG_CNT_W
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [RATE_W-1:0] eff_code;
  logic [RATE_W-1:0] shift;

  always_comb begin
    eff_code = rate_i;
    if (rate_i == RATE_W'(1))      eff_code = RATE_W'(prg_pkg::PRG_ALIAS_1);
    else if (rate_i == RATE_W'(2)) eff_code = RATE_W'(prg_pkg::PRG_ALIAS_2);
  end

  assign en_o  = (rate_i != '0);
  assign shift = eff_code - RATE_W'(1);

  // low 'shift' bits of the count must be zero at an event
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask_o[b] = (b < int'(shift));
  end
endmodule

// File: rtl/prg_evt_gen.sv
module prg_evt_gen #(
  parameter int unsigned CNT_W = prg_pkg::PRG_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             pie_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             pf_o,
  output logic             irq_o
);
  logic hit;
  logic pf_d;
  logic pf_q;
  logic irq_q;

  assign hit  = ((cnt_nxt_i & mask_i) == '0);
  assign pf_d = adv_i & ~clr_i & en_i & pie_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pf_q  <= pf_d;
      irq_q <= pf_d & pie_i;
    end
  end

  assign pf_o  = pf_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int unsigned CNT_W  = prg_pkg::PRG_CNT_W,
  parameter int unsigned RATE_W = prg_pkg::PRG_RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              pie_i,
  output logic              pf_set_o,
  output logic              irq_set_o
);
  logic             adv;
  logic             rate_en;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] mask;

  assign adv = tick_i & run_i;

  prg_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .adv_i     (adv),
    .cnt_nxt_o (cnt_nxt)
  );

  prg_rate_dec #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dec (
    .rate_i (rate_i),
    .en_o   (rate_en),
    .mask_o (mask)
  );

  prg_evt_gen #(.CNT_W(CNT_W)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .clr_i     (clr_i),
    .en_i      (rate_en),
    .pie_i     (pie_i),
    .cnt_nxt_i (cnt_nxt),
    .mask_i    (mask),
    .pf_o      (pf_set_o),
    .irq_o     (irq_set_o)
  );
endmodule

// File: rtl/prg_checker.sv
module prg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       tick_i,
  input logic       run_i,
  input logic [3:0] rate_i,
  input logic       pie_i,
  input logic       pf_set_o,
  input logic       irq_set_o
);
  assert_irq_needs_pf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_o |-> pf_set_o);
  assert_pf_has_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_set_o |-> irq_set_o);
  assert_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_set_o |=> !pf_set_o);
  assert_rate_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == 4'd0) |=> !pf_set_o);
  assert_pie_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pie_i |=> !pf_set_o);
  assert_run_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && run_i) |=> !pf_set_o);
  assert_clr_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pf_set_o);
endmodule

bind periodic_rate_gen prg_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .tick_i    (tick_i),
  .run_i     (run_i),
  .rate_i    (rate_i),
  .pie_i     (pie_i),
  .pf_set_o  (pf_set_o),
  .irq_set_o (irq_set_o)
);

// File: tb/tb_periodic_rate_gen.sv
`timescale 1ns/1ps
module tb_periodic_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       tick = 1'b0;
  logic       run = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       pie = 1'b0;
  logic       pf_set, irq_set;

  periodic_rate_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .tick_i(tick), .run_i(run),
    .rate_i(rate), .pie_i(pie), .pf_set_o(pf_set), .irq_set_o(irq_set)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit    pf;
    int    due;
    string tag;
  } exp_t;

  exp_t  sbq[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    ev_seen = 0;
  int    mdl_cnt = 0;
  bit    done = 1'b0;
  logic [3:0] cur_rate = 4'd0;
  bit    cur_pie = 1'b0;
  bit    cur_run = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(input logic [3:0] code);
    int c = int'(code);
    if (c == 1) c = 8;
    if (c == 2) c = 9;
    return 1 << (c - 1);
  endfunction

  // monitor: compare outputs against due expectations
  always @(negedge clk) begin
    if (pf_set) ev_seen = ev_seen + 1;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      total = total + 1;
      if (pf_set !== e.pf || irq_set !== e.pf) begin
        bad = bad + 1;
        $display("FAIL %s R7 R11 pf=%0b irq=%0b expected pf=%0b irq=%0b",
                 e.tag, pf_set, irq_set, e.pf, e.pf);
      end
    end
  end

  task automatic drive(input bit tk, input bit cl, input string tag);
    exp_t e;
    bit   ev = 1'b0;
    @(negedge clk);
    tick = tk; clr = cl; rate = cur_rate; pie = cur_pie; run = cur_run;
    if (cl) mdl_cnt = 0;
    else if (tk && cur_run) begin
      int n = (mdl_cnt + 1) % 32768;
      ev = (cur_rate != 4'd0) && cur_pie && ((n % period_of(cur_rate)) == 0);
      mdl_cnt = n;
    end
    e.pf = ev; e.due = cyc + 1; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic ticks(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, tag);
      for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, tag);
    end
  endtask

  task automatic flush_zero();
    drive(1'b0, 1'b0, "R10");
    drive(1'b0, 1'b0, "R10");
    ev_seen = 0;
  endtask

  task automatic window(input int expv, input string tag);
    drive(1'b0, 1'b0, "R10");
    drive(1'b0, 1'b0, "R10");
    total = total + 1;
    if (ev_seen != expv) begin
      bad = bad + 1;
      $display("FAIL %s event count=%0d expected=%0d", tag, ev_seen, expv);
    end
    ev_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    total = total + 1;
    if (pf_set !== 1'b0 || irq_set !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R1 reset pf=%0b irq=%0b expected pf=0 irq=0", pf_set, irq_set);
    end
    // R1/R3: first events after reset, code 3 = 4 ticks
    cur_rate = 4'd3; cur_pie = 1'b1; cur_run = 1'b1;
    flush_zero();
    ticks(40, 0, "R1 R3 code3");
    window(10, "R3 code3");
    // R4: code 1 aliases to 128 ticks
    cur_rate = 4'd1; drive(1'b0, 1'b1, "R9"); flush_zero();
    ticks(300, 0, "R4 code1");
    window(2, "R4 code1");
    // R4: code 2 aliases to 256 ticks
    cur_rate = 4'd2; drive(1'b0, 1'b1, "R9"); flush_zero();
    ticks(600, 0, "R4 code2");
    window(2, "R4 code2");
    // R2: code 0 silent
    cur_rate = 4'd0; flush_zero();
    ticks(300, 0, "R2 code0");
    window(0, "R2 code0");
    // R6: enable low silent, count keeps running
    cur_rate = 4'd6; cur_pie = 1'b0; flush_zero();
    ticks(100, 0, "R6 pie off");
    window(0, "R6 pie off");
    cur_pie = 1'b1;
    ticks(200, 0, "R6 R7 pie on");
    flush_zero();
    // R8: qualifier low holds the count
    cur_rate = 4'd3; drive(1'b0, 1'b1, "R9"); flush_zero();
    cur_run = 1'b0;
    ticks(10, 0, "R8 run low");
    window(0, "R8 run low");
    cur_run = 1'b1;
    ticks(3, 0, "R8 resume");
    window(0, "R8 resume");
    ticks(1, 0, "R8 resume");
    window(1, "R8 resume");
    // R5: alignment across rate changes
    drive(1'b0, 1'b1, "R9"); flush_zero();
    ticks(6, 0, "R5 code3");
    window(1, "R5 code3");
    cur_rate = 4'd4;
    ticks(1, 0, "R5 switch");
    window(0, "R5 no extra event");
    ticks(1, 0, "R5 switch");
    window(1, "R5 aligned to 8");
    cur_rate = 4'd5;
    ticks(8, 0, "R5 code5");
    window(1, "R5 aligned to 16");
    // R9: clear beats a tick
    cur_rate = 4'd3;
    ticks(2, 0, "R9 pre");
    drive(1'b1, 1'b1, "R9 clr+tick");
    flush_zero();
    ticks(3, 0, "R9 after clr");
    window(0, "R9 after clr");
    ticks(1, 0, "R9 after clr");
    window(1, "R9 after clr");
    // R10/R11: sparse ticks, code 6 = 32 ticks
    cur_rate = 4'd6; drive(1'b0, 1'b1, "R9"); flush_zero();
    ticks(64, 2, "R10 R11 sparse");
    window(2, "R10 sparse");
    // R3: code 15 = 16384 ticks
    cur_rate = 4'd15; drive(1'b0, 1'b1, "R9"); flush_zero();
    ticks(16384, 0, "R3 code15");
    window(1, "R3 code15");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule